// File: doc/BRIEF.md
# Power-On Reset and Watchdog Supervisor

This block produces the active-low reset line for a host processor. It combines three causes into one output. A hold timer keeps the line asserted for a fixed number of time-base ticks after the block leaves its own reset. A digital low-supply flag forces the line low while it is raised and restarts that hold delay. A watchdog counter asserts the same line when software fails to service it within a selected period.

All timing comes from a slow tick enable, nominally 1 kHz, so one tick stands for one millisecond. The watchdog period is picked with a 2-bit code. Code `00` selects 1750 ticks, `01` selects 750 ticks and `10` selects 250 ticks. Code `11` turns the watchdog off. Any one-cycle service strobe, such as a bus start condition detected elsewhere, restarts the watchdog count. The analog comparator sits outside this block and delivers the low-supply flag already synchronous to `clk`.

Top module: `rsup_supervisor`

## Requirements
- R1: After `rst_n` is released, `host_rst_n` stays low until the edge that samples the 250th cycle with `tick_ms` high. It goes high at that edge.
- R2: At any edge that samples `supply_low` high, `host_rst_n` goes low after that edge. It stays low for as long as `supply_low` remains high.
- R3: Once `supply_low` returns low, `host_rst_n` stays low for another 250 ticks. It goes high at the edge of the 250th tick.
- R4: With no service, the watchdog asserts `host_rst_n` low at the edge of the Nth tick after its count starts. N is 250 for code `10`, 750 for code `01` and 1750 for code `00`.
- R5: A reset caused by watchdog expiry lasts exactly 250 ticks. The watchdog then restarts from zero, so the next expiry needs a full period.
- R6: A cycle with `wd_kick` high clears the watchdog count. A tick in that same cycle is not counted.
- R7: With code `11`, the watchdog never asserts reset, however many ticks pass.
- R8: While `host_rst_n` is low, the watchdog count is held at zero. Service strobes do not change how long the reset lasts.
- R9: If the period code changes to one whose period is already used up by the elapsed count, the watchdog expires on the next tick and not before.
- R10: Cycles with `tick_ms` low advance neither the hold timer nor the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously by the caller |
| tick_ms | input | 1 | Time-base enable, one cycle high per tick |
| supply_low | input | 1 | Synchronous low-supply flag, active high |
| wd_kick | input | 1 | Watchdog service strobe, active high for one cycle |
| wd_sel | input | 2 | Watchdog period code: 00 long, 01 mid, 10 short, 11 off |
| host_rst_n | output | 1 | Active-low reset to the host processor |

## Verification
The bench counts the hold delay to the exact tick. It does this after power-up, after a supply dip and after a watchdog bite. A design whose counter is off by one, or that fails to restart the delay, releases one tick early or late. Each period code is run to its boundary. Service strobes are placed both alone and together with a tick, so a design that counts the coincident tick bites one tick early. Strobes are also sent while the reset is active, where a leaky design changes the reset length. A shorter period is selected after a long count has passed it. An equality compare would then miss the limit and wrap, never biting in time. A long stretch with no ticks exposes any counter that runs on the raw clock.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  // Watchdog period selection codes
  typedef enum logic [1:0] {
    WDP_LONG  = 2'b00,
    WDP_MID   = 2'b01,
    WDP_SHORT = 2'b10,
    WDP_OFF   = 2'b11
  } wdp_e;

  // Width needed to hold a count of 0..max_val
  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/rsup_period_dec.sv
module rsup_period_dec
  import rsup_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int SHORT_TICKS = 250,
  parameter int MID_TICKS   = 750,
  parameter int LONG_TICKS  = 1750
) (
  input  wdp_e             sel_i,
  output logic [CNT_W-1:0] last_idx_o,
  output logic             enabled_o
);

  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
  localparam logic [CNT_W-1:0] MID_LAST   = CNT_W'(MID_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);

  always_comb begin
    last_idx_o = '0;
    enabled_o  = 1'b1;
    case (sel_i)
      WDP_LONG:  last_idx_o = LONG_LAST;
      WDP_MID:   last_idx_o = MID_LAST;
      WDP_SHORT: last_idx_o = SHORT_LAST;
      default: begin
        last_idx_o = '0;
        enabled_o  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/rsup_wdt.sv
module rsup_wdt #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             hold_i,
  input  logic             enabled_i,
  input  logic [CNT_W-1:0] last_idx_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             running;
  logic             at_limit;

  // The count only runs when the host is out of reset, no service is seen
  // and a period is selected.
  assign running  = !hold_i && !kick_i && enabled_i;
  // Greater-or-equal so that a shrinking period cannot be skipped over
  assign at_limit = (cnt_q >= last_idx_i);
  assign expire_o = running && tick_i && at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (!running) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (at_limit) cnt_d = '0;
      else          cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: an active host reset leaves the watchdog cleared
  assert_wd_clear_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0));

  // R6: a service strobe leaves the watchdog cleared
  assert_kick_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0));

  // R7: a disabled watchdog does not count
  assert_off_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled_i |=> (cnt_q == '0));

endmodule

// File: rtl/rsup_hold.sv
module rsup_hold #(
  parameter int HOLD_TICKS = 250,
  parameter int HOLD_W     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic supply_low_i,
  input  logic wd_expire_i,
  output logic hold_o
);

  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_TICKS - 1);

  logic              hold_q, hold_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (supply_low_i || wd_expire_i) begin
      // Any new cause restarts the whole delay
      hold_d = 1'b1;
      cnt_d  = '0;
    end else if (hold_q && tick_i) begin
      if (cnt_q == HOLD_LAST) begin
        hold_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  assign hold_o = hold_q;

  // R10: the hold only ends on a cycle that carried a tick
  assert_release_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(tick_i));

  // R3: the hold does not end while the supply is flagged low
  assert_no_release_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> !$past(supply_low_i));

endmodule

// File: rtl/rsup_supervisor.sv
module rsup_supervisor
  import rsup_pkg::*;
#(
  parameter int HOLD_TICKS  = 250,
  parameter int SHORT_TICKS = 250,
  parameter int MID_TICKS   = 750,
  parameter int LONG_TICKS  = 1750
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       supply_low,
  input  logic       wd_kick,
  input  logic [1:0] wd_sel,
  output logic       host_rst_n
);

  localparam int WD_W   = cnt_width(LONG_TICKS);
  localparam int HOLD_W = cnt_width(HOLD_TICKS);

  wdp_e            sel;
  logic [WD_W-1:0] last_idx;
  logic            wd_enabled;
  logic            wd_expire;
  logic            hold;

  assign sel = wdp_e'(wd_sel);

  rsup_period_dec #(
    .CNT_W      (WD_W),
    .SHORT_TICKS(SHORT_TICKS),
    .MID_TICKS  (MID_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) u_dec (
    .sel_i     (sel),
    .last_idx_o(last_idx),
    .enabled_o (wd_enabled)
  );

  rsup_wdt #(
    .CNT_W(WD_W)
  ) u_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_ms),
    .kick_i    (wd_kick),
    .hold_i    (hold),
    .enabled_i (wd_enabled),
    .last_idx_i(last_idx),
    .expire_o  (wd_expire)
  );

  rsup_hold #(
    .HOLD_TICKS(HOLD_TICKS),
    .HOLD_W    (HOLD_W)
  ) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_ms),
    .supply_low_i(supply_low),
    .wd_expire_i (wd_expire),
    .hold_o      (hold)
  );

  assign host_rst_n = !hold;

  // R2: a low supply pulls the host into reset at the next edge
  assert_supply_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !host_rst_n);

  // R5: a watchdog bite pulls the host into reset at the next edge
  assert_expiry_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !host_rst_n);

  // R7: the off code never produces a bite
  assert_off_never_bites_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_sel == 2'b11) |-> !wd_expire);

endmodule

// File: tb/rsup_supervisor_tb.sv
`timescale 1ns/1ps
module rsup_supervisor_tb;

  localparam int HOLD  = 250;
  localparam int SHORT = 250;
  localparam int MID   = 750;
  localparam int LONG  = 1750;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_ms;
  logic       supply_low;
  logic       wd_kick;
  logic [1:0] wd_sel;
  logic       host_rst_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rsup_supervisor u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_ms   (tick_ms),
    .supply_low(supply_low),
    .wd_kick   (wd_kick),
    .wd_sel    (wd_sel),
    .host_rst_n(host_rst_n)
  );

  // Behavioural reference: reset flag, ticks spent in reset, ticks since service
  int m_hold = 1;
  int m_held = 0;
  int m_since = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold  = 1;
      m_held  = 0;
      m_since = 0;
    end else begin
      int period;
      bit bite;
      case (wd_sel)
        2'b10:   period = SHORT;
        2'b01:   period = MID;
        2'b00:   period = LONG;
        default: period = 0;
      endcase
      bite = 0;
      if (m_hold == 1 || wd_kick || period == 0) begin
        m_since = 0;
      end else if (tick_ms) begin
        if (m_since + 1 >= period) begin
          bite    = 1;
          m_since = 0;
        end else begin
          m_since = m_since + 1;
        end
      end
      if (supply_low || bite) begin
        m_hold = 1;
        m_held = 0;
      end else if (m_hold == 1 && tick_ms) begin
        m_held = m_held + 1;
        if (m_held == HOLD) begin
          m_hold = 0;
          m_held = 0;
        end
      end
    end
  end

  task automatic chk(input bit exp_val, input string what);
    checks++;
    if (host_rst_n !== exp_val) begin
      errors++;
      $display("FAIL %s: host_rst_n actual=%b expected=%b at %0t", what, host_rst_n, exp_val, $time);
    end
  endtask

  // One clock: drive at a falling edge, compare at the next falling edge
  task automatic step(input bit tk, input bit kk);
    tick_ms = tk;
    wd_kick = kk;
    @(negedge clk);
    checks++;
    if (host_rst_n !== (m_hold == 0)) begin
      errors++;
      $display("FAIL model compare (R1 to R10): host_rst_n actual=%b expected=%b at %0t",
               host_rst_n, (m_hold == 0), $time);
    end
  endtask

  task automatic tick_n(input int n, input bit kick_between = 0);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0);
      step(1'b0, kick_between);
    end
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog timeout (all requirements): actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    tick_ms    = 1'b0;
    supply_low = 1'b0;
    wd_kick    = 1'b0;
    wd_sel     = 2'b11;
    @(negedge clk);
    @(negedge clk);
    chk(1'b0, "R1 reset state");
    rst_n = 1'b1;

    // R10: no ticks, no progress
    idle_n(1000);
    chk(1'b0, "R10 hold frozen without ticks");

    // R1: power-on delay
    tick_n(HOLD - 1);
    chk(1'b0, "R1 still held one tick before end");
    tick_n(1);
    chk(1'b1, "R1 released at last tick");

    // R2 and R3: low supply and recovery
    supply_low = 1'b1;
    step(1'b0, 1'b0);
    chk(1'b0, "R2 low supply asserts reset");
    tick_n(300);
    chk(1'b0, "R2 held while supply low");
    supply_low = 1'b0;
    tick_n(HOLD - 1);
    chk(1'b0, "R3 still held one tick before end");
    tick_n(1);
    chk(1'b1, "R3 released after recovery delay");

    // R7: off code
    wd_sel = 2'b11;
    tick_n(2000);
    chk(1'b1, "R7 disabled watchdog never bites");

    // R4 short period
    wd_sel = 2'b10;
    step(1'b0, 1'b1);
    tick_n(SHORT - 1);
    chk(1'b1, "R4 short period not yet expired");
    tick_n(1);
    chk(1'b0, "R4 short period bite");

    // R8 and R5: kicks during reset do not shorten or lengthen it
    tick_n(HOLD - 1, 1'b1);
    chk(1'b0, "R8 kicks in reset leave it asserted");
    tick_n(1);
    chk(1'b1, "R5 bite reset lasts the hold delay");
    tick_n(SHORT - 1);
    chk(1'b1, "R5 watchdog restarted from zero");
    tick_n(1);
    chk(1'b0, "R5 next bite after full period");
    tick_n(HOLD);
    chk(1'b1, "R5 second release");

    // R6: service strobes
    tick_n(200);
    step(1'b0, 1'b1);
    tick_n(200);
    chk(1'b1, "R6 kick restarts count");
    step(1'b1, 1'b1);
    tick_n(SHORT - 1);
    chk(1'b1, "R6 tick with kick not counted");
    tick_n(1);
    chk(1'b0, "R6 bite after full period from kick");
    tick_n(HOLD);

    // R4 mid period
    wd_sel = 2'b01;
    tick_n(MID - 1);
    chk(1'b1, "R4 mid period not yet expired");
    tick_n(1);
    chk(1'b0, "R4 mid period bite");
    tick_n(HOLD);

    // R4 long period
    wd_sel = 2'b00;
    tick_n(LONG - 1);
    chk(1'b1, "R4 long period not yet expired");
    tick_n(1);
    chk(1'b0, "R4 long period bite");
    tick_n(HOLD);
    chk(1'b1, "R5 release after long bite");

    // R9: shrink the period past the elapsed count
    tick_n(500);
    wd_sel = 2'b10;
    idle_n(3);
    chk(1'b1, "R9 no bite without a tick");
    tick_n(1);
    chk(1'b0, "R9 bite on next tick after shrink");
    tick_n(HOLD);
    chk(1'b1, "R9 release after shrink bite");

    finish_run();
  end

endmodule